// File: doc/BRIEF.md
# Multiprocessor Address Recognition Filter

This block sits behind a UART receiver that runs in 9-bit multiprocessor mode. Every received frame is presented to it with its eight data bits and its ninth bit. When address recognition is on, a frame with the ninth bit at 1 is an address frame. The filter compares that address byte against two patterns held in two registers: a node address and a significance mask. If either pattern matches, the node becomes selected, and the data frames that follow (ninth bit at 0) are forwarded with a valid strobe. If neither pattern matches, the selection is dropped, and the data frames that follow are discarded without any signal.

The first pattern is the node's own address. Only the bit positions where the mask holds a 1 are compared; the other positions are don't-cares. The second pattern is the group-wide broadcast address. It is formed by OR-ing the address register with the mask register. Every 1 in that result must also be 1 in the received byte, and every 0 in it is a don't-care. With a chosen set of don't-care bits, a single address byte can reach one node, a chosen group of nodes, or every node. Both registers reset to zero. In that state every byte matches, so the filter behaves as if it were not there. When address recognition is off, every frame is forwarded unchanged.

A three-state controller tracks the selection. PASS is the state while address recognition is off. HUNT means recognition is on and the node is not selected. SELECT means the node is selected. The transitions are: enable (PASS to HUNT, or PASS to SELECT when a matching address frame arrives in the same cycle), hit (HUNT to SELECT), miss (SELECT to HUNT), and disable (any state to PASS). A non-matching address frame in HUNT, or a matching one in SELECT, leaves the state unchanged.

Top module: `mpf_addr_filter`

## Requirements
- R1: After reset, `fw_valid`, `addr_hit` and `selected` are 0.
- R2: With address recognition on, an address frame matches when the received byte equals the node address in every bit position where the mask bit is 1. For example, address E0h with mask F9h matches E6h and does not match E5h.
- R3: With address recognition on, an address frame also matches when every bit that is 1 in (address OR mask) is also 1 in the received byte. For example, address E0h with mask F9h matches FFh and FBh and does not match F7h.
- R4: While both registers hold their reset value of zero, any address byte matches.
- R5: A matching address frame pulses `addr_hit` and sets `selected` one cycle after the frame. Address frames are never forwarded on `fw_valid` while recognition is on.
- R6: A non-matching address frame clears `selected` one cycle after the frame and does not pulse `addr_hit`.
- R7: A data frame (ninth bit 0) that arrives while `selected` is 1 is forwarded one cycle later: `fw_valid` is 1 and `fw_data` equals the received byte.
- R8: A data frame that arrives while `selected` is 0 and recognition is on is dropped, so `fw_valid` stays 0.
- R9: With recognition off, every frame is forwarded one cycle later whatever its ninth bit is. In that mode `addr_hit` and `selected` stay 0.
- R10: A register write with `cfg_sel`=0 loads the node address, and a write with `cfg_sel`=1 loads the mask. The new value is used from the next frame on.
- R11: Turning recognition off clears `selected`. Turning it back on starts unselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 node address, 1 mask |
| cfg_wdata | input | DATA_W | Register write data |
| mp_mode_en | input | 1 | Address recognition enable |
| rx_valid | input | 1 | Received frame strobe |
| rx_bit9 | input | 1 | Ninth bit of the frame (1 = address frame) |
| rx_data | input | DATA_W | Eight data bits of the frame |
| fw_valid | output | 1 | Forwarded frame strobe |
| fw_data | output | DATA_W | Forwarded frame data |
| addr_hit | output | 1 | One-cycle pulse on a matching address frame |
| selected | output | 1 | Node currently selected |

## Verification
The bench builds the block with its default `DATA_W` of 8. That lets it use the byte patterns from the requirements directly: a given-address match, an exclusion caused by one significant bit, a broadcast that relies on don't-care zeros, and the all-zero reset state that accepts every byte. It walks the controller through every named transition. That includes a disable while the node is selected, and a re-enable followed by a data frame, which must be dropped.

// File: rtl/mpf_pkg.sv
package mpf_pkg;

    typedef enum logic [1:0] {
        ST_PASS   = 2'd0,
        ST_HUNT   = 2'd1,
        ST_SELECT = 2'd2
    } filt_state_e;

    localparam logic CFG_SEL_ADDR = 1'b0;
    localparam logic CFG_SEL_MASK = 1'b1;

endpackage

// File: rtl/mpf_cfg_regs.sv
module mpf_cfg_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] node_addr,
    output logic [DATA_W-1:0] node_mask
);
    import mpf_pkg::*;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            node_addr <= '0;
            node_mask <= '0;
        end else if (we) begin
            if (sel == CFG_SEL_MASK) begin
                node_mask <= wdata;
            end else begin
                node_addr <= wdata;
            end
        end
    end

endmodule

// File: rtl/mpf_match.sv
module mpf_match #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] rx_byte,
    input  logic [DATA_W-1:0] node_addr,
    input  logic [DATA_W-1:0] node_mask,
    output logic              hit
);
    logic [DATA_W-1:0] own_ok;
    logic [DATA_W-1:0] bcast_ok;

    // Per-bit verdicts: a bit passes the own-address test when it is
    // insignificant or equal; it passes the broadcast test when the
    // OR-pattern bit is 0 (don't-care) or the received bit is 1.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign own_ok[i]   = !node_mask[i] || (rx_byte[i] == node_addr[i]);
        assign bcast_ok[i] = rx_byte[i] || !(node_addr[i] || node_mask[i]);
    end

    assign hit = (&own_ok) || (&bcast_ok);

endmodule

// File: rtl/mpf_fsm.sv
module mpf_fsm #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mp_mode_en,
    input  logic              rx_valid,
    input  logic              rx_bit9,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              hit,
    output logic              fw_valid,
    output logic [DATA_W-1:0] fw_data,
    output logic              addr_hit,
    output logic              selected
);
    import mpf_pkg::*;

    filt_state_e state_q, state_n;
    logic        is_addr;

    assign is_addr = rx_valid && rx_bit9;

    // Next-state selection
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_PASS: begin
                if (mp_mode_en) begin
                    state_n = (is_addr && hit) ? ST_SELECT : ST_HUNT;
                end
            end
            ST_HUNT: begin
                if (!mp_mode_en) begin
                    state_n = ST_PASS;
                end else if (is_addr && hit) begin
                    state_n = ST_SELECT;
                end
            end
            ST_SELECT: begin
                if (!mp_mode_en) begin
                    state_n = ST_PASS;
                end else if (is_addr && !hit) begin
                    state_n = ST_HUNT;
                end
            end
            default: state_n = ST_PASS;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PASS;
        end else begin
            state_q <= state_n;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fw_valid <= 1'b0;
            fw_data  <= '0;
            addr_hit <= 1'b0;
        end else begin
            fw_valid <= rx_valid &&
                        (!mp_mode_en || (!rx_bit9 && state_q == ST_SELECT));
            if (rx_valid) begin
                fw_data <= rx_data;
            end
            addr_hit <= mp_mode_en && is_addr && hit;
        end
    end

    assign selected = (state_q == ST_SELECT);

endmodule

// File: rtl/mpf_addr_filter.sv
module mpf_addr_filter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              mp_mode_en,
    input  logic              rx_valid,
    input  logic              rx_bit9,
    input  logic [DATA_W-1:0] rx_data,
    output logic              fw_valid,
    output logic [DATA_W-1:0] fw_data,
    output logic              addr_hit,
    output logic              selected
);
    logic [DATA_W-1:0] node_addr;
    logic [DATA_W-1:0] node_mask;
    logic              hit;

    mpf_cfg_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .sel       (cfg_sel),
        .wdata     (cfg_wdata),
        .node_addr (node_addr),
        .node_mask (node_mask)
    );

    mpf_match #(.DATA_W(DATA_W)) u_match (
        .rx_byte   (rx_data),
        .node_addr (node_addr),
        .node_mask (node_mask),
        .hit       (hit)
    );

    mpf_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mp_mode_en (mp_mode_en),
        .rx_valid   (rx_valid),
        .rx_bit9    (rx_bit9),
        .rx_data    (rx_data),
        .hit        (hit),
        .fw_valid   (fw_valid),
        .fw_data    (fw_data),
        .addr_hit   (addr_hit),
        .selected   (selected)
    );

endmodule

// File: rtl/mpf_addr_filter_chk.sv
module mpf_addr_filter_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mp_mode_en,
    input logic              rx_valid,
    input logic              rx_bit9,
    input logic [DATA_W-1:0] rx_data,
    input logic              fw_valid,
    input logic [DATA_W-1:0] fw_data,
    input logic              addr_hit,
    input logic              selected
);

    assert_hit_selects_R5: assert property (@(posedge clk) disable iff (!rst_n)
        addr_hit |-> selected);

    assert_addr_not_fwd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mp_mode_en && rx_valid && rx_bit9) |=> !fw_valid);

    assert_fwd_when_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mp_mode_en && rx_valid && !rx_bit9 && selected) |=> fw_valid);

    assert_fwd_needs_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fw_valid |-> $past(rx_valid));

    assert_drop_unsel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mp_mode_en && rx_valid && !rx_bit9 && !selected) |=> !fw_valid);

    assert_pass_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mp_mode_en && rx_valid) |=> (fw_valid && fw_data == $past(rx_data)));

    assert_off_unsel_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !mp_mode_en |=> (!selected && !addr_hit));

endmodule

bind mpf_addr_filter mpf_addr_filter_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mp_mode_en (mp_mode_en),
    .rx_valid   (rx_valid),
    .rx_bit9    (rx_bit9),
    .rx_data    (rx_data),
    .fw_valid   (fw_valid),
    .fw_data    (fw_data),
    .addr_hit   (addr_hit),
    .selected   (selected)
);

// File: tb/mpf_addr_filter_tb.sv
module mpf_addr_filter_tb;

    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic              cfg_sel = 1'b0;
    logic [DATA_W-1:0] cfg_wdata = '0;
    logic              mp_mode_en = 1'b0;
    logic              rx_valid = 1'b0;
    logic              rx_bit9 = 1'b0;
    logic [DATA_W-1:0] rx_data = '0;
    logic              fw_valid;
    logic [DATA_W-1:0] fw_data;
    logic              addr_hit;
    logic              selected;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mpf_addr_filter #(.DATA_W(DATA_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .mp_mode_en (mp_mode_en),
        .rx_valid   (rx_valid),
        .rx_bit9    (rx_bit9),
        .rx_data    (rx_data),
        .fw_valid   (fw_valid),
        .fw_data    (fw_data),
        .addr_hit   (addr_hit),
        .selected   (selected)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic sel, input logic [DATA_W-1:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drive one frame for one cycle; outputs are sampled one negedge later.
    task automatic frame(input logic b9, input logic [DATA_W-1:0] d);
        @(negedge clk);
        rx_valid = 1'b1; rx_bit9 = b9; rx_data = d;
        @(negedge clk);
        rx_valid = 1'b0; rx_bit9 = 1'b0;
    endtask

    task automatic set_mode(input logic on);
        @(negedge clk);
        mp_mode_en = on;
        @(negedge clk);
    endtask

    task automatic addr_expect(input string req, input logic [DATA_W-1:0] d,
                               input logic exp_hit);
        frame(1'b1, d);
        chk(req, "addr_hit", addr_hit, exp_hit);
        chk(req, "selected", selected, exp_hit);
        chk("R5", "addr frame fw_valid", fw_valid, 1'b0);
    endtask

    task automatic t_reset;
        chk("R1", "fw_valid", fw_valid, 1'b0);
        chk("R1", "addr_hit", addr_hit, 1'b0);
        chk("R1", "selected", selected, 1'b0);
    endtask

    task automatic t_defaults;
        set_mode(1'b1);
        chk("R11", "selected on enable", selected, 1'b0);
        addr_expect("R4", 8'h5A, 1'b1);
        frame(1'b0, 8'h33);
        chk("R7", "fw_valid", fw_valid, 1'b1);
        chk("R7", "fw_data", fw_data, 8'h33);
        chk("R5", "addr_hit pulse ends", addr_hit, 1'b0);
    endtask

    task automatic t_given;
        wr_reg(1'b0, 8'hE0);
        wr_reg(1'b1, 8'hF9);
        addr_expect("R2", 8'hE6, 1'b1);
        addr_expect("R6", 8'hE5, 1'b0);
        frame(1'b0, 8'h44);
        chk("R8", "dropped fw_valid", fw_valid, 1'b0);
        wr_reg(1'b1, 8'hFC);
        addr_expect("R10", 8'hE3, 1'b1);
        addr_expect("R2", 8'hE4, 1'b0);
        wr_reg(1'b0, 8'hE8);
        addr_expect("R10", 8'hEB, 1'b1);
        addr_expect("R10", 8'hE3, 1'b0);
    endtask

    task automatic t_bcast;
        wr_reg(1'b0, 8'hE0);
        wr_reg(1'b1, 8'hF9);
        addr_expect("R3", 8'hFF, 1'b1);
        addr_expect("R3", 8'hF7, 1'b0);
        addr_expect("R3", 8'hFB, 1'b1);
        frame(1'b0, 8'hA5);
        chk("R7", "fw_data after bcast", fw_data, 8'hA5);
        chk("R7", "fw_valid after bcast", fw_valid, 1'b1);
    endtask

    task automatic t_mode_off;
        set_mode(1'b0);
        chk("R11", "selected after disable", selected, 1'b0);
        frame(1'b1, 8'h12);
        chk("R9", "addr frame fw_valid", fw_valid, 1'b1);
        chk("R9", "addr frame fw_data", fw_data, 8'h12);
        chk("R9", "addr_hit", addr_hit, 1'b0);
        chk("R9", "selected", selected, 1'b0);
        frame(1'b0, 8'h34);
        chk("R9", "data fw_valid", fw_valid, 1'b1);
        chk("R9", "data fw_data", fw_data, 8'h34);
    endtask

    task automatic t_reenable;
        set_mode(1'b1);
        chk("R11", "selected after enable", selected, 1'b0);
        frame(1'b0, 8'h56);
        chk("R11", "data dropped after enable", fw_valid, 1'b0);
        addr_expect("R2", 8'hE6, 1'b1);
        set_mode(1'b0);
        chk("R11", "disable clears selected", selected, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_defaults();
        t_given();
        t_bcast();
        t_mode_off();
        t_reenable();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule